// File: doc/BRIEF.md
# Segment Relocation and Limit Checker

This block turns logical addresses into physical ones for a processor with no paging. It holds two relocation segments, each a base and a limit. One segment serves instruction fetches and the other serves data loads and stores. A fetch can therefore use a shared code segment while each task keeps its own data segment. For every request the block adds the segment's base to the logical address. It compares the logical address, unsigned, against the segment's limit. When the address is at or beyond the limit, the access is marked as out of range and no memory access is allowed to go ahead.

Privileged software loads the four segment registers through a small configuration port, and can read them back through the same port. The port only works while the processor runs in supervisor mode. In user mode a write is refused, the register keeps its old value, and a fault output pulses. A user-mode read returns zero. The translation path is combinational. A parameter can add one register stage on its outputs.

Top module: `seg_xlate_top`

## Requirements
- R1: The physical address equals the logical address plus the selected segment's base, modulo 2^ADDR_W. The carry out of the addition is dropped.
- R2: The violation output is high exactly when a request is valid and its logical address, taken as unsigned, is greater than or equal to the selected segment's limit. A fetch (`reqIsFetch`=1) uses the code segment and a data access (`reqIsFetch`=0) uses the data segment.
- R3: On a violation the physical address is still driven, but `physValid` is low. With `reqValid` low, both `physValid` and `limitViolation` are low.
- R4: A configuration write in supervisor mode loads `cfgData` into the register chosen by `cfgSel` at the next rising clock edge. The `cfgSel` encoding is: 0 code base, 1 code limit, 2 data base, 3 data limit.
- R5: A configuration write attempted in user mode leaves every register unchanged. It drives `privFault` high for the one cycle that follows the clock edge at which the write was presented.
- R6: In supervisor mode `cfgRdData` shows the register chosen by `cfgSel`. In user mode it reads as zero.
- R7: Reset clears all four registers to zero, so every valid access violates until software loads the registers.
- R8: With OUT_REG=0 the outputs follow the request in the same cycle. With OUT_REG=1 they carry the same values one clock edge later, and reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supervisorMode | input | 1 | 1 when the processor runs privileged code |
| cfgWrEn | input | 1 | Configuration write request |
| cfgSel | input | 2 | Register select for reads and writes |
| cfgData | input | ADDR_W | Configuration write data |
| cfgRdData | output | ADDR_W | Configuration read data (zero in user mode) |
| privFault | output | 1 | One-cycle pulse after a refused user-mode write |
| reqValid | input | 1 | Translation request present |
| reqIsFetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| reqAddr | input | ADDR_W | Logical address |
| physAddr | output | ADDR_W | Relocated physical address |
| physValid | output | 1 | Access may proceed to memory |
| limitViolation | output | 1 | Logical address is at or beyond the segment limit |

## Verification
The bench builds two instances side by side, both with ADDR_W=6. One has OUT_REG=0 and the other OUT_REG=1. The narrow width lets the bench sweep all 64 logical addresses through both segments under several base and limit settings. These settings include a limit of zero, a limit at the top code value, and a base large enough that the sum wraps. The bench compares every result with sums and comparisons it works out itself. Running the registered copy on the same stimulus checks, at every address, that it matches the combinational copy one edge later.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int NUM_SEG_REGS = 4;
  localparam int SEL_W = $clog2(NUM_SEG_REGS);

  localparam logic [SEL_W-1:0] SEL_CODE_BASE  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CODE_LIMIT = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DATA_BASE  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_DATA_LIMIT = 2'd3;

  typedef struct packed {
    logic [NUM_SEG_REGS-1:0] wrOneHot;
    logic                    rdAllowed;
    logic [SEL_W-1:0]        rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             supervisorMode,
  input  logic             cfgWrEn,
  input  logic [SEL_W-1:0] cfgSel,
  output ctrlStrobes_t     strobes,
  output logic             privFault
);
  logic grantWrite;
  logic refuseWrite;

  assign grantWrite  = cfgWrEn & supervisorMode;
  assign refuseWrite = cfgWrEn & ~supervisorMode;

  for (genvar i = 0; i < NUM_SEG_REGS; i++) begin : g_dec
    assign strobes.wrOneHot[i] = grantWrite && (cfgSel == SEL_W'(i));
  end

  assign strobes.rdAllowed = supervisorMode;
  assign strobes.rdSel     = cfgSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) privFault <= 1'b0;
    else       privFault <= refuseWrite;
  end

  // R5: a refused write is reported on the following cycle
  assert_user_write_faults_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !supervisorMode) |=> privFault);

  // R5: no fault without a refused write in the cycle before
  assert_fault_has_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && !supervisorMode) |=> !privFault);

  // R4: write strobes are at most one-hot and only in supervisor mode
  assert_strobe_privileged_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrOneHot) && (!supervisorMode -> strobes.wrOneHot == '0));
endmodule

// File: rtl/seg_xlate_dpath.sv
module seg_xlate_dpath
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [ADDR_W-1:0] cfgRdData,
  input  logic              reqValid,
  input  logic              reqIsFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] physAddr,
  output logic              physValid,
  output logic              limitViolation
);
  logic [ADDR_W-1:0] segRegs [NUM_SEG_REGS];

  for (genvar i = 0; i < NUM_SEG_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   segRegs[i] <= '0;
      else if (strobes.wrOneHot[i]) segRegs[i] <= cfgData;
    end

    // R5: a register without a write strobe keeps its value
    assert_hold_without_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.wrOneHot[i] |=> $stable(segRegs[i]));

    // R4: a granted write lands on the next edge
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rstN)
      strobes.wrOneHot[i] |=> segRegs[i] == $past(cfgData));
  end

  assign cfgRdData = strobes.rdAllowed ? segRegs[strobes.rdSel] : '0;

  logic [ADDR_W-1:0] selBase;
  logic [ADDR_W-1:0] selLimit;
  logic [ADDR_W-1:0] sumAddr;
  logic              outOfRange;
  logic              nextViol;
  logic              nextValid;

  always_comb begin
    selBase    = reqIsFetch ? segRegs[SEL_CODE_BASE]  : segRegs[SEL_DATA_BASE];
    selLimit   = reqIsFetch ? segRegs[SEL_CODE_LIMIT] : segRegs[SEL_DATA_LIMIT];
    sumAddr    = reqAddr + selBase;
    outOfRange = (reqAddr >= selLimit);
    nextViol   = reqValid & outOfRange;
    nextValid  = reqValid & ~outOfRange;
  end

  if (OUT_REG) begin : g_outReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        physAddr       <= '0;
        physValid      <= 1'b0;
        limitViolation <= 1'b0;
      end else begin
        physAddr       <= sumAddr;
        physValid      <= nextValid;
        limitViolation <= nextViol;
      end
    end

    // R8: registered outputs follow the request one edge later
    assert_stage_delay_R8: assert property (@(posedge clk) disable iff (!rstN)
      $past(reqValid) == (physValid || limitViolation));
  end else begin : g_outComb
    assign physAddr       = sumAddr;
    assign physValid      = nextValid;
    assign limitViolation = nextViol;
  end

  // R3: an out-of-range access never reaches memory
  assert_violation_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    limitViolation |-> !physValid);

  // R7: a zero limit after reset makes every valid access violate
  assert_zero_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!OUT_REG && reqValid && selLimit == '0) |-> limitViolation);
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supervisorMode,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [ADDR_W-1:0] cfgRdData,
  output logic              privFault,
  input  logic              reqValid,
  input  logic              reqIsFetch,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] physAddr,
  output logic              physValid,
  output logic              limitViolation
);
  ctrlStrobes_t strobes;

  seg_xlate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .supervisorMode(supervisorMode),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .strobes(strobes), .privFault(privFault)
  );

  seg_xlate_dpath #(.ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgData(cfgData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqIsFetch(reqIsFetch),
    .reqAddr(reqAddr), .physAddr(physAddr), .physValid(physValid),
    .limitViolation(limitViolation)
  );
endmodule

// File: tb/tb_seg_xlate_top.sv
`timescale 1ns/1ps
module tb_seg_xlate_top;
  localparam int AW = 6;
  localparam int SPAN = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supervisorMode = 1'b1;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [AW-1:0] cfgData = '0;
  logic reqValid = 1'b0;
  logic reqIsFetch = 1'b0;
  logic [AW-1:0] reqAddr = '0;

  logic [AW-1:0] rdC, rdR, paC, paR;
  logic pfC, pfR, pvC, pvR, lvC, lvR;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int codeBase, codeLim, dataBase, dataLim;

  always #2 clk = ~clk;

  seg_xlate_top #(.ADDR_W(AW), .OUT_REG(1'b0)) dut (
    .clk(clk), .rstN(rstN), .supervisorMode(supervisorMode), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgData(cfgData), .cfgRdData(rdC), .privFault(pfC),
    .reqValid(reqValid), .reqIsFetch(reqIsFetch), .reqAddr(reqAddr),
    .physAddr(paC), .physValid(pvC), .limitViolation(lvC));

  seg_xlate_top #(.ADDR_W(AW), .OUT_REG(1'b1)) dutReg (
    .clk(clk), .rstN(rstN), .supervisorMode(supervisorMode), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgData(cfgData), .cfgRdData(rdR), .privFault(pfR),
    .reqValid(reqValid), .reqIsFetch(reqIsFetch), .reqAddr(reqAddr),
    .physAddr(paR), .physValid(pvR), .limitViolation(lvR));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(input int sel, input int val, input bit sup);
    @(negedge clk);
    supervisorMode = sup; cfgWrEn = 1'b1; cfgSel = 2'(sel); cfgData = AW'(val);
    @(negedge clk);
    cfgWrEn = 1'b0; supervisorMode = 1'b1;
  endtask

  task automatic loadAll(input int cb, input int cl, input int db, input int dl);
    writeReg(0, cb, 1'b1); writeReg(1, cl, 1'b1);
    writeReg(2, db, 1'b1); writeReg(3, dl, 1'b1);
    codeBase = cb; codeLim = cl; dataBase = db; dataLim = dl;
  endtask

  task automatic sweep(input bit fetch, input bit valid);
    for (int a = 0; a < SPAN; a++) begin
      int base, lim, expPa, expV, expL;
      @(negedge clk);
      reqValid = valid; reqIsFetch = fetch; reqAddr = AW'(a);
      base = fetch ? codeBase : dataBase;
      lim  = fetch ? codeLim  : dataLim;
      expPa = (a + base) % SPAN;
      expL  = (valid && a >= lim) ? 1 : 0;
      expV  = (valid && a < lim) ? 1 : 0;
      #1;
      check("R1 comb physAddr", int'(paC), expPa);
      check("R2 comb violation", int'(lvC), expL);
      check("R3 comb physValid", int'(pvC), expV);
      @(posedge clk); #1;
      check("R8 reg physAddr", int'(paR), expPa);
      check("R8 reg violation", int'(lvR), expL);
      check("R8 reg physValid", int'(pvR), expV);
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R8 reg outputs cleared in reset", int'(paR) + int'(pvR) + int'(lvR), 0);
    @(negedge clk); rstN = 1'b1;

    // R7: registers read zero after reset
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); cfgSel = 2'(s); #1;
      check("R7 reset register value", int'(rdC), 0);
    end
    codeBase = 0; codeLim = 0; dataBase = 0; dataLim = 0;
    // R7: all valid accesses violate from reset
    sweep(1'b1, 1'b1);
    sweep(1'b0, 1'b1);

    // R4/R6: supervisor writes and reads back; sel 0..3 encoding
    loadAll(10, 20, 60, 40);
    for (int s = 0; s < 4; s++) begin
      int exp;
      exp = (s == 0) ? 10 : (s == 1) ? 20 : (s == 2) ? 60 : 40;
      @(negedge clk); cfgSel = 2'(s); #1;
      check("R4 write then readback", int'(rdC), exp);
      check("R6 readback reg instance", int'(rdR), exp);
    end
    // R6: user-mode read returns zero
    @(negedge clk); supervisorMode = 1'b0; cfgSel = 2'd1; #1;
    check("R6 user read zero", int'(rdC), 0);
    @(negedge clk); supervisorMode = 1'b1;

    sweep(1'b1, 1'b1);   // R1 R2 code segment
    sweep(1'b0, 1'b1);   // R1 wrap in data segment
    sweep(1'b1, 1'b0);   // R3 idle requests

    // R5: user write refused, fault pulses one cycle
    @(negedge clk);
    supervisorMode = 1'b0; cfgWrEn = 1'b1; cfgSel = 2'd2; cfgData = AW'(5);
    @(posedge clk); #1;
    check("R5 fault pulse high", int'(pfC), 1);
    check("R5 fault pulse high reg inst", int'(pfR), 1);
    @(negedge clk);
    cfgWrEn = 1'b0; supervisorMode = 1'b1;
    @(posedge clk); #1;
    check("R5 fault pulse ends", int'(pfC), 0);
    @(negedge clk); cfgSel = 2'd2; #1;
    check("R5 register unchanged", int'(rdC), 60);
    // no fault on a supervisor write
    writeReg(3, 63, 1'b1);
    dataLim = 63;
    #1;
    check("R5 no fault on privileged write", int'(pfC), 0);

    // Limit at top code value, data base zero
    writeReg(2, 0, 1'b1); dataBase = 0;
    sweep(1'b0, 1'b1);
    // Limit zero on code segment with large base
    writeReg(1, 0, 1'b1); writeReg(0, 63, 1'b1);
    codeLim = 0; codeBase = 63;
    sweep(1'b1, 1'b1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule